// File: doc/BRIEF.md
# Address Tenure Tracker

This block follows the address phase of each transaction on a split-transaction processor bus. It watches the start strobe, the address acknowledge and the bus-wide retry line. From these it marks the one cycle in which retry decides the outcome of a tenure, and it reports with one-cycle flags whether the tenure completed or was aborted. It also shows when a new start strobe may be issued.

When a tenure is retried, the cycle after the retry window becomes a request-drop window. The local bus request is forced low in that window unless the local device was one of the retriers. The tracker also records the identity of the acknowledging device, which is the slave for the tenure. It flags two protocol faults:
- a start strobe while a tenure is still open;
- a retry that is asserted before the window but released before it.

Top module: `addr_tenure_tracker`

## Requirements
- R1: While reset is active and in the first cycle after it, start_ok_o is 1, retry_win_o, drop_win_o, done_o, abort_o, proto_err_o and hold_err_o are 0, and slave_id_o is 0.
- R2: A start strobe seen while start_ok_o is 1 opens a tenure. start_ok_o is 0 from the next cycle until the tenure closes.
- R3: An acknowledge seen while a tenure waits for it makes retry_win_o 1 for exactly the next cycle.
- R4: If retry is low during the retry window, done_o is 1 for the next cycle only, and start_ok_o is 1 in that same cycle.
- R5: If retry is high during the retry window, abort_o and drop_win_o are both 1 for the next cycle only. start_ok_o returns to 1 the cycle after that.
- R6: local_req_o equals local_req_i in every cycle except the drop window. In the drop window it is 0 when local_retry_i was 0 during the retry window, and equals local_req_i when local_retry_i was 1.
- R7: A start strobe while start_ok_o is 0 makes proto_err_o 1 for the next cycle and does not open a tenure.
- R8: If retry is high in any cycle from the cycle after the start strobe through the acknowledge cycle, but low in the retry window, hold_err_o is 1 for the cycle after the window.
- R9: On an accepted acknowledge, slave_id_o takes the value of ack_id_i from the next cycle and holds it until the next accepted acknowledge.
- R10: An acknowledge or retry while no tenure is open changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_i | input | 1 | Transaction start strobe |
| aack_i | input | 1 | Address acknowledge |
| ack_id_i | input | ID_W | Identity of the acknowledging device |
| artry_i | input | 1 | Bus-wide address retry |
| local_retry_i | input | 1 | Local device is driving retry |
| local_req_i | input | 1 | Local bus request, before gating |
| local_req_o | output | 1 | Local bus request, after drop-window gating |
| start_ok_o | output | 1 | A new start strobe is permitted |
| retry_win_o | output | 1 | Retry sampling window |
| drop_win_o | output | 1 | Request-drop window |
| done_o | output | 1 | Tenure completed |
| abort_o | output | 1 | Tenure aborted by retry |
| proto_err_o | output | 1 | Start strobe while a tenure is open |
| hold_err_o | output | 1 | Early retry not held into the window |
| slave_id_o | output | ID_W | Identity of the current slave |

## Verification
The bench builds the block with the default ID_W of 4. This is wide enough to tell apart two distinct slave identities (5 and 10) across back-to-back tenures. Under these parameters, a table of per-cycle vectors reaches every state transition: clean completion, retry with and without local participation, early retry released before the window, and start strobes in each open state. Directed cases cover reset, including reset in mid-tenure, and slave capture.

// File: rtl/att_pkg.sv
package att_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RWIN = 2'd2,
    ST_DROP = 2'd3
  } tenure_st_e;
endpackage

// File: rtl/att_fsm.sv
module att_fsm
  import att_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ts_i,
  input  logic       aack_i,
  input  logic       artry_i,
  output tenure_st_e state_o,
  output logic       done_o,
  output logic       abort_o,
  output logic       proto_err_o
);
  tenure_st_e state_q, state_d;
  logic done_q, abort_q, perr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ts_i)   state_d = ST_WAIT;
      ST_WAIT: if (aack_i) state_d = ST_RWIN;
      ST_RWIN: state_d = artry_i ? ST_DROP : ST_IDLE;
      ST_DROP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RWIN) && !artry_i;
      abort_q <= (state_q == ST_RWIN) && artry_i;
      perr_q  <= ts_i && (state_q != ST_IDLE);
    end
  end

  assign state_o     = state_q;
  assign done_o      = done_q;
  assign abort_o     = abort_q;
  assign proto_err_o = perr_q;

  a_r3_win_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && aack_i) |=> (state_q == ST_RWIN));
  a_r4_done_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RWIN && !artry_i) |=> (done_o && state_q == ST_IDLE));
  a_r5_abort_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RWIN && artry_i) |=> (abort_o && state_q == ST_DROP));
  a_r5_drop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |=> (state_q == ST_IDLE));
  a_r4_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, abort_o}));
endmodule

// File: rtl/att_retry_hold.sv
module att_retry_hold
  import att_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  tenure_st_e state_i,
  input  logic       artry_i,
  input  logic       local_retry_i,
  output logic       hold_err_o,
  output logic       local_retried_o
);
  logic seen_q, herr_q, lret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      herr_q <= 1'b0;
      lret_q <= 1'b0;
    end else begin
      // early retry memory, cleared when no tenure is open
      if (state_i == ST_WAIT) seen_q <= seen_q | artry_i;
      else if (state_i == ST_IDLE) seen_q <= 1'b0;
      herr_q <= (state_i == ST_RWIN) && seen_q && !artry_i;
      if (state_i == ST_RWIN) lret_q <= local_retry_i;
    end
  end

  assign hold_err_o      = herr_q;
  assign local_retried_o = lret_q;

  a_r8_err_only_after_win: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_err_o |-> $past(state_i == ST_RWIN && !artry_i));
endmodule

// File: rtl/att_slave_cap.sv
module att_slave_cap #(
  parameter int ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_q <= '0;
    else if (take_i) id_q <= id_i;
  end

  assign id_o = id_q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(id_o));
endmodule

// File: rtl/addr_tenure_tracker.sv
module addr_tenure_tracker
  import att_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ts_i,
  input  logic            aack_i,
  input  logic [ID_W-1:0] ack_id_i,
  input  logic            artry_i,
  input  logic            local_retry_i,
  input  logic            local_req_i,
  output logic            local_req_o,
  output logic            start_ok_o,
  output logic            retry_win_o,
  output logic            drop_win_o,
  output logic            done_o,
  output logic            abort_o,
  output logic            proto_err_o,
  output logic            hold_err_o,
  output logic [ID_W-1:0] slave_id_o
);
  tenure_st_e state;
  logic       local_retried;

  att_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ts_i        (ts_i),
    .aack_i      (aack_i),
    .artry_i     (artry_i),
    .state_o     (state),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .proto_err_o (proto_err_o)
  );

  att_retry_hold u_hold (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .state_i         (state),
    .artry_i         (artry_i),
    .local_retry_i   (local_retry_i),
    .hold_err_o      (hold_err_o),
    .local_retried_o (local_retried)
  );

  att_slave_cap #(.ID_W(ID_W)) u_slave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (state == ST_WAIT && aack_i),
    .id_i   (ack_id_i),
    .id_o   (slave_id_o)
  );

  assign start_ok_o  = (state == ST_IDLE);
  assign retry_win_o = (state == ST_RWIN);
  assign drop_win_o  = (state == ST_DROP);
  assign local_req_o = local_req_i && !(drop_win_o && !local_retried);

  a_r6_drop_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_win_o && artry_i && !local_retry_i) |=> !local_req_o);
  a_r7_err_on_busy_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i && !start_ok_o) |=> proto_err_o);
  a_r2_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i && start_ok_o) |=> !start_ok_o);
  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && aack_i) |=> (slave_id_o == $past(ack_id_i)));
endmodule

// File: tb/sim_addr_tenure_tracker.sv
module sim_addr_tenure_tracker;
  localparam int ID_W = 4;
  localparam int NV   = 27;
  // {ts,aack,artry,lretry,lreq, rwin,dwin,sok,done,abort,perr,herr,lreqo}
  localparam logic [12:0] VEC [NV] = '{
    13'b10000_00000000, 13'b00000_00000000, 13'b01000_10000000,
    13'b00000_00110000, 13'b10000_00000000, 13'b01101_10000001,
    13'b00101_01001000, 13'b00001_00100001, 13'b10000_00000000,
    13'b01000_10000000, 13'b00111_01001001, 13'b00000_00100000,
    13'b10000_00000000, 13'b10000_00000100, 13'b00100_00000000,
    13'b01100_10000000, 13'b00000_00110010, 13'b10000_00000000,
    13'b01000_10000000, 13'b10000_00110100, 13'b10000_00000000,
    13'b01000_10000000, 13'b00100_01001000, 13'b10000_00100100,
    13'b01000_00100000, 13'b00100_00100000, 13'b00001_00100001
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts = 0, aack = 0, artry = 0, lretry = 0, lreq = 0;
  logic [ID_W-1:0] ack_id = '0;
  logic lreq_o, sok, rwin, dwin, done, abort, perr, herr;
  logic [ID_W-1:0] sid;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  addr_tenure_tracker #(.ID_W(ID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ts_i(ts), .aack_i(aack), .ack_id_i(ack_id),
    .artry_i(artry), .local_retry_i(lretry), .local_req_i(lreq),
    .local_req_o(lreq_o), .start_ok_o(sok), .retry_win_o(rwin),
    .drop_win_o(dwin), .done_o(done), .abort_o(abort), .proto_err_o(perr),
    .hold_err_o(herr), .slave_id_o(sid)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d @%0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic [4:0] in, input logic [ID_W-1:0] id);
    @(negedge clk);
    {ts, aack, artry, lretry, lreq} = in;
    ack_id = id;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    #12;
    chk("R1 start_ok", sok, 1);
    chk("R1 windows", {rwin, dwin}, 0);
    chk("R1 flags", {done, abort, perr, herr}, 0);
    chk("R1 slave_id", sid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 start_ok after release", sok, 1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:8], '0);
      chk($sformatf("R3 retry_win v%0d", i), rwin, VEC[i][7]);
      chk($sformatf("R5 drop_win v%0d", i),  dwin, VEC[i][6]);
      chk($sformatf("R2 start_ok v%0d", i),  sok,  VEC[i][5]);
      chk($sformatf("R4 done v%0d", i),      done, VEC[i][4]);
      chk($sformatf("R5 abort v%0d", i),     abort, VEC[i][3]);
      chk($sformatf("R7 proto_err v%0d", i), perr, VEC[i][2]);
      chk($sformatf("R8 hold_err v%0d", i),  herr, VEC[i][1]);
      chk($sformatf("R6 local_req v%0d", i), lreq_o, VEC[i][0]);
      if (i >= 24) chk($sformatf("R10 idle ignore v%0d", i), {rwin, dwin, done, abort}, 0);
    end

    // R9 slave capture across two tenures
    step(5'b10000, 4'd0);
    step(5'b01000, 4'd5);
    chk("R9 slave_id first", sid, 5);
    step(5'b00000, 4'd9);
    chk("R9 slave_id held", sid, 5);
    step(5'b10000, 4'd3);
    chk("R9 slave_id held on start", sid, 5);
    step(5'b01000, 4'd10);
    chk("R9 slave_id second", sid, 10);
    step(5'b01000, 4'd7);
    chk("R9 ack in window ignored", sid, 10);

    // R1 reset mid-tenure
    step(5'b10000, 4'd0);
    chk("R2 open before reset", sok, 0);
    @(negedge clk); rst_n = 1'b0; ts = 0; aack = 0;
    #1;
    chk("R1 async reset start_ok", sok, 1);
    chk("R1 async reset slave_id", sid, 0);
    @(negedge clk); rst_n = 1'b1;
    step(5'b01000, 4'd6);
    chk("R10 ack after reset ignored", rwin, 0);
    chk("R10 slave_id untouched", sid, 0);

    finish_run();
  end
endmodule